// File: doc/BRIEF.md
# Serial Target Front End with Bus Pause

This block is the bit-level front end of a serial memory-style target. It oversamples the serial clock, the active-low select, the active-low pause line and the serial data input with a faster system clock. It assembles incoming bytes and serializes outgoing bytes in SPI mode 0, most significant bit first. Incoming bits are captured on serial-clock rising edges and outgoing bits advance on falling edges. Command decoding, storage and the program/erase engine sit behind it and talk to it through a byte strobe and a byte-load request.

A pause condition lets a host share the serial bus with other devices without deselecting this target and without stopping its clock. While paused, every serial-clock edge is ignored, the output driver is released and all interface state is kept. A quad-mode configuration input turns the pause function off, because the pause pin then carries data. Deselecting the target during a pause clears the interface. The busy indication from the embedded engine passes straight through, so a pause never stops an operation that is already running.

Top module: `spi_hold_frontend`

## Requirements
- R1: While reset is asserted and after it is released with the target deselected, so_oe, hold_active, rx_valid and tx_req are 0 and rx_byte is 0.
- R2: With the target selected and no pause, si is sampled on each sck rising edge, MSB first. After every eighth sample, rx_byte holds the assembled byte and rx_valid is 1 for exactly one system clock.
- R3: tx_byte is taken, and tx_req is 1 for one system clock, when csn falls and on the sck falling edge that follows every eighth rising edge. so_out shows the loaded byte MSB first and advances one bit on each other sck falling edge.
- R4: so_oe is 1 exactly when the target is selected (csn low) and no pause is active.
- R5: With csn low and quad_en 0, holdn going low while sck is low starts the pause. If sck is high, the pause starts once sck goes low. holdn low while csn is high has no effect.
- R6: holdn going high while sck is low ends the pause. If sck is high, the pause ends once sck goes low.
- R7: During a pause, sck edges are ignored. The bit count and both shift registers keep their values, and the byte resumes intact after the pause.
- R8: csn going high during a pause ends the pause and discards the partial byte. No rx_valid is issued for it.
- R9: csn going high outside a pause discards any partial byte. The next selection starts a fresh byte.
- R10: While quad_en is 1, holdn has no effect and hold_active stays 0.
- R11: busy_out always equals busy_in, including during a pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the sck rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_pin | input | 1 | Serial clock from the host |
| csn_pin | input | 1 | Active-low target select |
| holdn_pin | input | 1 | Active-low bus pause |
| si_pin | input | 1 | Serial data from the host |
| quad_en | input | 1 | Quad-mode configuration; 1 disables the pause |
| busy_in | input | 1 | Busy flag from the embedded engine |
| tx_byte | input | DATA_W | Next byte to send, taken when tx_req pulses |
| rx_byte | output | DATA_W | Last complete received byte |
| rx_valid | output | 1 | One-clock strobe per received byte |
| tx_req | output | 1 | One-clock strobe when tx_byte is taken |
| so_out | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for so_out |
| hold_active | output | 1 | Pause condition in force |
| busy_out | output | 1 | Copy of busy_in |

## Verification
A bit counter that is off by one, or that moves during a pause, shows up at the next rx_valid as a rotated or corrupted rx_byte. so_out shows the same fault on the next bit that the host samples, so the error is visible within one byte time. If the pause flag is updated at the wrong point relative to sck, hold_active changes while sck is still high, or a stray edge is accepted. The bench probes hold_active a few system clocks after each pin change, and it compares every byte that crosses the interface in both directions.

// File: rtl/spi_hold_pkg.sv
`timescale 1ns/1ps
package spi_hold_pkg;
   // Order of the synchronized pin bundle.
   typedef struct packed {
      logic sck;
      logic cs_n;
      logic hold_n;
      logic si;
   } pin_bus_t;

   localparam int PIN_COUNT = $bits(pin_bus_t);

   // Idle pin levels: clock low, deselected, no pause, data low.
   localparam pin_bus_t PIN_IDLE = '{sck: 1'b0, cs_n: 1'b1, hold_n: 1'b1, si: 1'b0};
endpackage

// File: rtl/shd_sync.sv
`timescale 1ns/1ps
module shd_sync #(
   parameter int              WIDTH   = 4,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      initial $fatal(1, "shd_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      initial $fatal(1, "shd_sync: WIDTH must be at least 1");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
         else        chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/shd_hold_ctrl.sv
`timescale 1ns/1ps
module shd_hold_ctrl #(
   parameter bit HOLD_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_s,
   input  logic cs_n_s,
   input  logic hold_n_s,
   input  logic quad_en,
   output logic hold_q
);
   if (HOLD_EN) begin : g_hold
      // The pause flag may only change while the clock is low; a deselect
      // or quad mode clears it at any time.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        hold_q <= 1'b0;
         else if (cs_n_s)   hold_q <= 1'b0;
         else if (quad_en)  hold_q <= 1'b0;
         else if (!sck_s)   hold_q <= ~hold_n_s;
      end

      a_r5_entry_on_low_sck : assert property (@(posedge clk) disable iff (!rst_n)
         $rose(hold_q) |-> (!$past(sck_s) && !$past(cs_n_s)));
      a_r6_exit_on_low_sck : assert property (@(posedge clk) disable iff (!rst_n)
         $fell(hold_q) |-> (!$past(sck_s) || $past(cs_n_s) || $past(quad_en)));
      a_r8_deselect_clears : assert property (@(posedge clk) disable iff (!rst_n)
         cs_n_s |=> !hold_q);
      a_r10_quad_blocks : assert property (@(posedge clk) disable iff (!rst_n)
         quad_en |=> !hold_q);
   end else begin : g_no_hold
      assign hold_q = 1'b0;
   end
endmodule

// File: rtl/shd_shifter.sv
`timescale 1ns/1ps
module shd_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_s,
   input  logic              cs_n_s,
   input  logic              si_s,
   input  logic              hold,
   input  logic [DATA_W-1:0] tx_byte,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_valid,
   output logic              tx_req,
   output logic              so
);
   localparam int              CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

   if (DATA_W < 2) begin : g_bad_w
      initial $fatal(1, "shd_shifter: DATA_W must be at least 2");
   end

   logic              sck_d, cs_d;
   logic              rise, fall, cs_fall;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-2:0] rx_sr;
   logic [DATA_W-1:0] tx_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         cs_d  <= 1'b1;
      end else begin
         sck_d <= sck_s;
         cs_d  <= cs_n_s;
      end
   end

   assign rise    = sck_s & ~sck_d;
   assign fall    = ~sck_s & sck_d;
   assign cs_fall = cs_d & ~cs_n_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         rx_sr    <= '0;
         tx_sr    <= '0;
         rx_byte  <= '0;
         rx_valid <= 1'b0;
         tx_req   <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         tx_req   <= 1'b0;
         if (cs_n_s) begin
            cnt   <= '0;
            rx_sr <= '0;
            tx_sr <= '0;
         end else if (cs_fall) begin
            cnt    <= '0;
            tx_sr  <= tx_byte;
            tx_req <= 1'b1;
         end else if (!hold) begin
            if (rise) begin
               rx_sr <= {rx_sr[DATA_W-3:0], si_s};
               if (cnt == LAST) begin
                  cnt      <= '0;
                  rx_byte  <= {rx_sr, si_s};
                  rx_valid <= 1'b1;
               end else begin
                  cnt <= cnt + ONE;
               end
            end else if (fall) begin
               if (cnt == '0) begin
                  tx_sr  <= tx_byte;
                  tx_req <= 1'b1;
               end else begin
                  tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign so = tx_sr[DATA_W-1];

   a_r2_strobe_single : assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
   a_r2_strobe_on_wrap : assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> (cnt == '0));
   a_r3_load_on_boundary : assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |-> (cnt == '0));
   a_r7_frozen_in_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !cs_n_s) |=> ($stable(cnt) && $stable(rx_sr) && $stable(tx_sr) && !rx_valid));
   a_r9_deselect_clears_count : assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> (cnt == '0));
endmodule

// File: rtl/spi_hold_frontend.sv
`timescale 1ns/1ps
module spi_hold_frontend
   import spi_hold_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit HOLD_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_pin,
   input  logic              csn_pin,
   input  logic              holdn_pin,
   input  logic              si_pin,
   input  logic              quad_en,
   input  logic              busy_in,
   input  logic [DATA_W-1:0] tx_byte,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_valid,
   output logic              tx_req,
   output logic              so_out,
   output logic              so_oe,
   output logic              hold_active,
   output logic              busy_out
);
   pin_bus_t pins_raw, pins_s;
   logic     hold_q;

   assign pins_raw = '{sck: sck_pin, cs_n: csn_pin, hold_n: holdn_pin, si: si_pin};

   shd_sync #(
      .WIDTH   (PIN_COUNT),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_raw),
      .q     (pins_s)
   );

   shd_hold_ctrl #(
      .HOLD_EN (HOLD_EN)
   ) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck_s    (pins_s.sck),
      .cs_n_s   (pins_s.cs_n),
      .hold_n_s (pins_s.hold_n),
      .quad_en  (quad_en),
      .hold_q   (hold_q)
   );

   shd_shifter #(
      .DATA_W (DATA_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck_s    (pins_s.sck),
      .cs_n_s   (pins_s.cs_n),
      .si_s     (pins_s.si),
      .hold     (hold_q),
      .tx_byte  (tx_byte),
      .rx_byte  (rx_byte),
      .rx_valid (rx_valid),
      .tx_req   (tx_req),
      .so       (so_out)
   );

   assign so_oe       = ~pins_s.cs_n & ~hold_q;
   assign hold_active = hold_q;
   assign busy_out    = busy_in;

   a_r4_released_when_idle : assert property (@(posedge clk) disable iff (!rst_n)
      $past(pins_s.cs_n) |-> !so_oe || !pins_s.cs_n);
endmodule

// File: tb/sim_spi_hold_frontend.sv
`timescale 1ns/1ps
module sim_spi_hold_frontend;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b0, csn = 1'b1, holdn = 1'b1, si = 1'b0;
   logic       quad_en = 1'b0, busy_in = 1'b0;
   logic [7:0] tx_byte = 8'h00;
   logic [7:0] rx_byte;
   logic       rx_valid, tx_req, so_out, so_oe, hold_active, busy_out;

   int total = 0, bad = 0;
   int rx_n = 0, tx_n = 0;
   bit done = 1'b0;
   logic [7:0] rx_log [0:511];

   always #4 clk = ~clk;

   spi_hold_frontend u0 (
      .clk(clk), .rst_n(rst_n), .sck_pin(sck), .csn_pin(csn), .holdn_pin(holdn),
      .si_pin(si), .quad_en(quad_en), .busy_in(busy_in), .tx_byte(tx_byte),
      .rx_byte(rx_byte), .rx_valid(rx_valid), .tx_req(tx_req), .so_out(so_out),
      .so_oe(so_oe), .hold_active(hold_active), .busy_out(busy_out)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_valid) begin
            if (rx_n < 512) rx_log[rx_n] = rx_byte;
            rx_n++;
         end
         if (tx_req) tx_n++;
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sbits(input logic [7:0] v, input int hi, input int lo, inout logic [7:0] got);
      for (int i = hi; i >= lo; i--) begin
         si = v[i];
         wclk(4);
         got[i] = so_out;
         sck = 1'b1;
         wclk(4);
         sck = 1'b0;
      end
   endtask

   task automatic junk(input int n);
      for (int i = 0; i < n; i++) begin
         si = ~si;
         wclk(4);
         sck = 1'b1;
         wclk(4);
         sck = 1'b0;
      end
      wclk(4);
   endtask

   task automatic last_rx(input logic [7:0] exp, input int cnt_exp, input string req);
      chk(rx_n == cnt_exp, req, "byte count", rx_n, cnt_exp);
      if (rx_n > 0) chk(rx_log[rx_n-1] == exp, req, "received byte", rx_log[rx_n-1], exp);
   endtask

   initial begin
      wclk(150000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] got;
      int base, tbase;

      // R1: reset state
      wclk(3);
      chk(so_oe == 1'b0 && hold_active == 1'b0, "R1", "oe/hold in reset", {so_oe, hold_active}, 0);
      rst_n = 1'b1;
      wclk(5);
      chk({so_oe, hold_active, rx_valid, tx_req} == 4'b0, "R1", "flags after reset",
          {so_oe, hold_active, rx_valid, tx_req}, 0);
      chk(rx_byte == 8'h00, "R1", "rx_byte after reset", rx_byte, 0);

      // R2/R3: exhaustive byte sweep in one selection, tx = k ^ A5
      base = rx_n; tbase = tx_n;
      tx_byte = 8'hA5;
      csn = 1'b0;
      wclk(5);
      chk(so_oe == 1'b1, "R4", "oe when selected", so_oe, 1);
      for (int k = 0; k < 256; k++) begin
         got = 8'h00;
         sbits(8'(k), 7, 7, got);
         tx_byte = 8'(k + 1) ^ 8'hA5;
         sbits(8'(k), 6, 0, got);
         chk(rx_n == base + k + 1, "R2", "strobe count", rx_n, base + k + 1);
         chk(rx_log[base + k] == 8'(k), "R2", "received byte", rx_log[base + k], k);
         chk(got == (8'(k) ^ 8'hA5), "R3", "sent byte", got, 8'(k) ^ 8'hA5);
      end
      wclk(6);
      chk(tx_n == tbase + 257, "R3", "load strobe count", tx_n - tbase, 257);
      csn = 1'b1;
      wclk(6);
      chk(so_oe == 1'b0, "R4", "oe when deselected", so_oe, 0);

      // R5: pause while deselected has no effect
      holdn = 1'b0;
      wclk(6);
      chk(hold_active == 1'b0, "R5", "pause while deselected", hold_active, 0);
      holdn = 1'b1;
      wclk(4);

      // R5/R6/R7/R11: pause entered and left with sck low
      base = rx_n;
      tx_byte = 8'h3C;
      csn = 1'b0;
      wclk(5);
      got = 8'h00;
      sbits(8'hC9, 7, 5, got);
      holdn = 1'b0;
      wclk(5);
      chk(hold_active == 1'b1, "R5", "pause entry, sck low", hold_active, 1);
      chk(so_oe == 1'b0, "R4", "oe released in pause", so_oe, 0);
      busy_in = 1'b1;
      wclk(1);
      chk(busy_out == 1'b1, "R11", "busy in pause", busy_out, 1);
      busy_in = 1'b0;
      wclk(1);
      chk(busy_out == 1'b0, "R11", "busy cleared", busy_out, 0);
      junk(3);
      chk(rx_n == base, "R7", "no strobe in pause", rx_n - base, 0);
      holdn = 1'b1;
      wclk(5);
      chk(hold_active == 1'b0, "R6", "pause exit, sck low", hold_active, 0);
      chk(so_oe == 1'b1, "R4", "oe back after pause", so_oe, 1);
      sbits(8'hC9, 4, 0, got);
      last_rx(8'hC9, base + 1, "R7");
      chk(got == 8'h3C, "R7", "sent byte across pause", got, 8'h3C);
      csn = 1'b1;
      wclk(6);

      // R5/R6/R7: pause requested and released while sck high
      base = rx_n;
      tx_byte = 8'h96;
      csn = 1'b0;
      wclk(5);
      got = 8'h00;
      sbits(8'h5A, 7, 6, got);
      si = 1'b0;
      wclk(4);
      got[5] = so_out;
      sck = 1'b1;
      wclk(2);
      holdn = 1'b0;
      wclk(5);
      chk(hold_active == 1'b0, "R5", "entry waits for sck low", hold_active, 0);
      sck = 1'b0;
      wclk(5);
      chk(hold_active == 1'b1, "R5", "entry at sck low", hold_active, 1);
      junk(2);
      sck = 1'b1;
      wclk(4);
      holdn = 1'b1;
      wclk(5);
      chk(hold_active == 1'b1, "R6", "exit waits for sck low", hold_active, 1);
      sck = 1'b0;
      wclk(5);
      chk(hold_active == 1'b0, "R6", "exit at sck low", hold_active, 0);
      sbits(8'h5A, 4, 0, got);
      last_rx(8'h5A, base + 1, "R7");
      chk(got == 8'h96, "R7", "sent byte, high-sck pause", got, 8'h96);
      csn = 1'b1;
      wclk(6);

      // R8: deselect during pause
      base = rx_n;
      tx_byte = 8'hE1;
      csn = 1'b0;
      wclk(5);
      got = 8'h00;
      sbits(8'hFF, 7, 4, got);
      holdn = 1'b0;
      wclk(5);
      chk(hold_active == 1'b1, "R8", "pause before deselect", hold_active, 1);
      csn = 1'b1;
      wclk(5);
      chk(hold_active == 1'b0, "R8", "deselect ends pause", hold_active, 0);
      chk(so_oe == 1'b0, "R8", "oe after deselect", so_oe, 0);
      holdn = 1'b1;
      wclk(4);
      csn = 1'b0;
      wclk(5);
      got = 8'h00;
      sbits(8'h81, 7, 0, got);
      last_rx(8'h81, base + 1, "R8");
      chk(got == 8'hE1, "R8", "sent byte after reset", got, 8'hE1);
      csn = 1'b1;
      wclk(6);

      // R9: deselect mid-byte without pause
      base = rx_n;
      tx_byte = 8'h0F;
      csn = 1'b0;
      wclk(5);
      got = 8'h00;
      sbits(8'h00, 7, 5, got);
      csn = 1'b1;
      wclk(6);
      chk(rx_n == base, "R9", "no strobe for partial byte", rx_n - base, 0);
      csn = 1'b0;
      wclk(5);
      got = 8'h00;
      sbits(8'h7E, 7, 0, got);
      last_rx(8'h7E, base + 1, "R9");
      chk(got == 8'h0F, "R9", "sent byte after restart", got, 8'h0F);
      csn = 1'b1;
      wclk(6);

      // R10: quad mode ignores the pause line
      base = rx_n;
      quad_en = 1'b1;
      tx_byte = 8'h42;
      csn = 1'b0;
      wclk(5);
      got = 8'h00;
      sbits(8'hB7, 7, 4, got);
      holdn = 1'b0;
      wclk(5);
      chk(hold_active == 1'b0, "R10", "no pause in quad", hold_active, 0);
      chk(so_oe == 1'b1, "R10", "oe stays in quad", so_oe, 1);
      sbits(8'hB7, 3, 0, got);
      last_rx(8'hB7, base + 1, "R10");
      chk(got == 8'h42, "R10", "sent byte in quad", got, 8'h42);
      holdn = 1'b1;
      csn = 1'b1;
      quad_en = 1'b0;
      wclk(6);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule